// File: doc/BRIEF.md
# PWM Dither Offset Generator

This block produces a signed correction that is added to the base duty of a pulse-width channel. The correction is a symmetric triangle or square wave. Its period is set in microseconds and its peak height in percent of full duty. The wave's height does not switch on and off at once. When the dither enable rises, the height climbs in a straight line from zero to the programmed peak. When the enable falls, the height sinks back to zero. The climb and the descent each have their own duration in milliseconds. The two durations come packed in one 32-bit word: the climb time in the lower half and the descent time in the upper half.

Two single-cycle strobes set the pace. A 1 µs strobe advances the wave phase, and a 1 ms strobe advances the height ramp. The block adds the wave to the base duty, given in per-mille, and clamps the sum to 0..1000. It presents the clamped duty together with the offset that was actually applied. A busy flag tells the surrounding logic when dithering is in effect. The pulse generator itself sits outside this block.

Top module: `dither_gen`

## Requirements
- R1: After reset, busy is 0, the applied offset is 0 and, one cycle after the inputs settle, the duty output equals the base duty.
- R2: With the enable high and a climb time T>0, the height rises on each ms strobe by floor(P/T) plus one whenever a remainder accumulator (adding P mod T per strobe) reaches T. P is the full height in per-mille, 10 × percent. The height therefore reaches P after exactly T strobes.
- R3: When the enable falls, the height falls from its current value, even a partial one, by max(P, height)/T_down per ms strobe, using the same remainder carry, and stops at 0.
- R4: A climb or descent time of 0 moves the height to its target on the next clock edge, with no ms strobe needed.
- R5: While both ramp times are non-zero, the height changes only in a cycle that carries an ms strobe.
- R6: Triangle shape (shape input 0), with h = period/2 rounded down and phase k: x = k when k ≤ h, otherwise period−k. The offset is height·(2x−h)/h, truncated toward zero. It starts at −height at phase 0.
- R7: Square shape (shape input 1): the offset is −height for phases below h and +height for the rest.
- R8: The phase advances by one on each µs strobe, wraps to 0 at the period, and is held at 0 while busy is low. A height of 0 gives an offset of 0.
- R9: The duty output is base+wave, clamped to 0..1000. The offset output is the clamped duty minus the base.
- R10: busy is 1 while the enable is high (delayed by one register) or while the height is non-zero.
- R11: A percent value above 100 is treated as 100, so the full height is 1000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dith_en | input | 1 | Dither enable; its edges start the climb or the descent |
| wave_shape | input | 1 | 0 selects triangle, 1 selects square |
| amp_pct | input | 7 | Peak height in percent |
| period_us | input | 16 | Wave period in µs strobes |
| ramp_ms | input | 32 | Climb time in ms [15:0], descent time in ms [31:16] |
| tick_us | input | 1 | Single-cycle 1 µs strobe |
| tick_ms | input | 1 | Single-cycle 1 ms strobe |
| base_duty | input | 10 | Base duty in per-mille |
| duty_out | output | 10 | Clamped duty in per-mille |
| duty_offset | output | 12 | Signed offset actually applied |
| busy | output | 1 | Dithering in effect |

## Verification
The ramp step and the phase step can land in the same cycle, when the ms strobe and the µs strobe arrive together. The bench pulses both strobes in one cycle, using a two-µs period so that every phase gives a different sign. It then checks that the registered offset combines the newly stepped height with the newly advanced phase, and not an older value of either. A second case has the enable fall during a partial climb. The descent must start from the partial height and must not jump from the programmed peak.

// File: rtl/dith_pkg.sv
package dith_pkg;
    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } dith_dir_e;

    typedef enum logic {
        WAVE_TRI = 1'b0,
        WAVE_SQR = 1'b1
    } dith_wave_e;
endpackage

// File: rtl/dith_ramp.sv
module dith_ramp
    import dith_pkg::*;
#(
    parameter int DUTY_MAX = 1000,
    parameter int PCT_W    = 7,
    parameter int RAMP_W   = 16,
    localparam int LVL_W   = $clog2(DUTY_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [PCT_W-1:0]  amp_pct_i,
    input  logic [RAMP_W-1:0] t_up_i,
    input  logic [RAMP_W-1:0] t_dn_i,
    input  logic              tick_ms_i,
    output logic [LVL_W-1:0]  level_o,
    output logic              busy_o
);
    localparam int PCT_FULL = 100;
    localparam int SCALE    = DUTY_MAX / PCT_FULL;

    typedef struct packed {
        logic [LVL_W-1:0]  level;
        logic [RAMP_W-1:0] err;
        dith_dir_e         dir;
        logic              en;
    } ramp_st_t;

    ramp_st_t cur_q, nxt_d;

    logic [PCT_W-1:0]  pct;
    logic [LVL_W-1:0]  full, target;
    logic [RAMP_W-1:0] tsel;
    dith_dir_e         dir_now;
    logic [31:0]       tdiv, base, quo, rem, err_use, acc, step, lvl32, tgt32;
    logic              carry;

    always_comb begin
        pct    = (amp_pct_i > PCT_W'(PCT_FULL)) ? PCT_W'(PCT_FULL) : amp_pct_i;
        full   = LVL_W'(32'(pct) * 32'(SCALE));
        target = en_i ? full : '0;
        if (cur_q.level < target)      dir_now = DIR_UP;
        else if (cur_q.level > target) dir_now = DIR_DOWN;
        else                           dir_now = DIR_HOLD;
        tsel    = (dir_now == DIR_UP) ? t_up_i : t_dn_i;
        tdiv    = (tsel == '0) ? 32'd1 : 32'(tsel);
        base    = (full > cur_q.level) ? 32'(full) : 32'(cur_q.level);
        quo     = base / tdiv;
        rem     = base % tdiv;
        err_use = (dir_now == cur_q.dir) ? 32'(cur_q.err) : 32'd0;
        acc     = err_use + rem;
        carry   = (acc >= tdiv);
        step    = quo + 32'(carry);
        lvl32   = 32'(cur_q.level);
        tgt32   = 32'(target);

        nxt_d     = cur_q;
        nxt_d.en  = en_i;
        nxt_d.dir = dir_now;
        nxt_d.err = RAMP_W'(err_use);
        if (dir_now == DIR_HOLD) begin
            nxt_d.err = '0;
        end else if (tsel == '0) begin
            nxt_d.level = target;
            nxt_d.err   = '0;
        end else if (tick_ms_i) begin
            nxt_d.err = RAMP_W'(carry ? acc - tdiv : acc);
            if (dir_now == DIR_UP) begin
                if (lvl32 + step >= tgt32) begin
                    nxt_d.level = target;
                    nxt_d.err   = '0;
                end else begin
                    nxt_d.level = LVL_W'(lvl32 + step);
                end
            end else begin
                if (lvl32 > tgt32 + step) begin
                    nxt_d.level = LVL_W'(lvl32 - step);
                end else begin
                    nxt_d.level = target;
                    nxt_d.err   = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{level: '0, err: '0, dir: DIR_HOLD, en: 1'b0};
        else        cur_q <= nxt_d;
    end

    assign level_o = cur_q.level;
    assign busy_o  = cur_q.en | (cur_q.level != '0);

    a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.level <= LVL_W'(DUTY_MAX));
    a_r5_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_ms_i && t_up_i != '0 && t_dn_i != '0) |=> $stable(cur_q.level));
    a_r3_no_rise_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i) |=> (cur_q.level <= $past(cur_q.level)));
    a_r10_busy_level: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o != '0) |-> busy_o);
endmodule

// File: rtl/dith_wave.sv
module dith_wave
    import dith_pkg::*;
#(
    parameter int PER_W = 16,
    parameter int LVL_W = 10,
    localparam int OFF_W = LVL_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    busy_i,
    input  logic                    tick_us_i,
    input  logic                    shape_i,
    input  logic [PER_W-1:0]        period_i,
    input  logic [LVL_W-1:0]        level_i,
    output logic signed [OFF_W-1:0] wave_o
);
    typedef struct packed {
        logic [PER_W-1:0] ph;
    } wave_st_t;

    wave_st_t cur_q, nxt_d;

    logic [PER_W-1:0]   half, xpos;
    logic signed [47:0] lvl_s, dev_s, num_s, res_s;

    always_comb begin
        nxt_d = cur_q;
        if (!busy_i) begin
            nxt_d.ph = '0;
        end else if (tick_us_i) begin
            if (32'(cur_q.ph) + 32'd1 >= 32'(period_i)) nxt_d.ph = '0;
            else                                        nxt_d.ph = cur_q.ph + 1'b1;
        end
    end

    always_comb begin
        half  = period_i >> 1;
        xpos  = (cur_q.ph <= half) ? cur_q.ph : period_i - cur_q.ph;
        lvl_s = signed'(48'(level_i));
        dev_s = signed'(48'(xpos)) * 48'sd2 - signed'(48'(half));
        num_s = lvl_s * dev_s;
        if (half == '0)              res_s = '0;
        else if (shape_i == WAVE_SQR) res_s = (cur_q.ph < half) ? -lvl_s : lvl_s;
        else                          res_s = num_s / signed'(48'(half));
        wave_o = OFF_W'(res_s);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    a_r8_phase_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i) |=> (cur_q.ph == '0));
    a_r8_zero_level: assert property (@(posedge clk) disable iff (!rst_n)
        (level_i == '0) |-> (wave_o == '0));
endmodule

// File: rtl/dith_sat.sv
module dith_sat #(
    parameter int DUTY_MAX = 1000,
    parameter int LVL_W    = 10,
    localparam int OFF_W   = LVL_W + 2,
    localparam int SUM_W   = OFF_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LVL_W-1:0]        base_i,
    input  logic signed [OFF_W-1:0] wave_i,
    output logic [LVL_W-1:0]        duty_o,
    output logic signed [OFF_W-1:0] offs_o
);
    typedef struct packed {
        logic [LVL_W-1:0]        duty;
        logic signed [OFF_W-1:0] offs;
    } sat_st_t;

    sat_st_t cur_q, nxt_d;

    logic [LVL_W-1:0]        base_c;
    logic signed [SUM_W-1:0] base_s, wav_s, sum_s, clip_s;

    always_comb begin
        base_c = (base_i > LVL_W'(DUTY_MAX)) ? LVL_W'(DUTY_MAX) : base_i;
        base_s = signed'(SUM_W'(base_c));
        wav_s  = SUM_W'(wave_i);
        sum_s  = base_s + wav_s;
        if (sum_s < 0)                              clip_s = '0;
        else if (sum_s > signed'(SUM_W'(DUTY_MAX))) clip_s = signed'(SUM_W'(DUTY_MAX));
        else                                        clip_s = sum_s;
        nxt_d.duty = LVL_W'(clip_s);
        nxt_d.offs = OFF_W'(clip_s - base_s);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign duty_o = cur_q.duty;
    assign offs_o = cur_q.offs;

    a_r9_duty_range: assert property (@(posedge clk) disable iff (!rst_n)
        duty_o <= LVL_W'(DUTY_MAX));
    a_r9_offs_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_i >= 0) |=> (offs_o >= 0));
endmodule

// File: rtl/dither_gen.sv
module dither_gen
    import dith_pkg::*;
#(
    parameter int DUTY_MAX = 1000,
    parameter int PCT_W    = 7,
    parameter int PER_W    = 16,
    parameter int RAMP_W   = 16,
    localparam int LVL_W   = $clog2(DUTY_MAX + 1),
    localparam int OFF_W   = LVL_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dith_en,
    input  logic                    wave_shape,
    input  logic [PCT_W-1:0]        amp_pct,
    input  logic [PER_W-1:0]        period_us,
    input  logic [2*RAMP_W-1:0]     ramp_ms,
    input  logic                    tick_us,
    input  logic                    tick_ms,
    input  logic [LVL_W-1:0]        base_duty,
    output logic [LVL_W-1:0]        duty_out,
    output logic signed [OFF_W-1:0] duty_offset,
    output logic                    busy
);
    logic [LVL_W-1:0]        level;
    logic signed [OFF_W-1:0] wave;

    dith_ramp #(.DUTY_MAX(DUTY_MAX), .PCT_W(PCT_W), .RAMP_W(RAMP_W)) ramp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (dith_en),
        .amp_pct_i (amp_pct),
        .t_up_i    (ramp_ms[RAMP_W-1:0]),
        .t_dn_i    (ramp_ms[2*RAMP_W-1:RAMP_W]),
        .tick_ms_i (tick_ms),
        .level_o   (level),
        .busy_o    (busy)
    );

    dith_wave #(.PER_W(PER_W), .LVL_W(LVL_W)) wave_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy_i    (busy),
        .tick_us_i (tick_us),
        .shape_i   (wave_shape),
        .period_i  (period_us),
        .level_i   (level),
        .wave_o    (wave)
    );

    dith_sat #(.DUTY_MAX(DUTY_MAX), .LVL_W(LVL_W)) sat_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .base_i (base_duty),
        .wave_i (wave),
        .duty_o (duty_out),
        .offs_o (duty_offset)
    );
endmodule

// File: tb/dither_gen_tb_top.sv
`timescale 1ns/1ps
module dither_gen_tb_top;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               dith_en = 1'b0;
    logic               wave_shape = 1'b0;
    logic [6:0]         amp_pct = 7'd50;
    logic [15:0]        period_us = 16'd4;
    logic [31:0]        ramp_ms = {16'd5, 16'd3};
    logic               tick_us = 1'b0;
    logic               tick_ms = 1'b0;
    logic [9:0]         base_duty = 10'd500;
    logic [9:0]         duty_out;
    logic signed [11:0] duty_offset;
    logic               busy;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dither_gen dut_i (
        .clk(clk), .rst_n(rst_n), .dith_en(dith_en), .wave_shape(wave_shape),
        .amp_pct(amp_pct), .period_us(period_us), .ramp_ms(ramp_ms),
        .tick_us(tick_us), .tick_ms(tick_ms), .base_duty(base_duty),
        .duty_out(duty_out), .duty_offset(duty_offset), .busy(busy)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe(input logic us, input logic ms);
        @(negedge clk);
        tick_us = us;
        tick_ms = ms;
        @(negedge clk);
        tick_us = 1'b0;
        tick_ms = 1'b0;
        @(negedge clk);
    endtask

    task automatic offs_is(input string tag, input int exp);
        check(tag, int'(duty_offset), exp);
    endtask

    task automatic clear_all();
        ramp_ms = 32'd0;
        dith_en = 1'b0;
        cyc(3);
    endtask

    task automatic t_reset();
        cyc(2);
        check("R1 busy after reset", int'(busy), 0);
        offs_is("R1 offset after reset", 0);
        check("R1 duty follows base", int'(duty_out), 500);
    endtask

    task automatic t_ramp_up();
        wave_shape = 1'b1; period_us = 16'd4; ramp_ms = {16'd5, 16'd3};
        dith_en = 1'b1;
        cyc(2);
        check("R10 busy on enable", int'(busy), 1);
        offs_is("R2 height zero before strobe", 0);
        strobe(1'b0, 1'b1); offs_is("R2 climb step 1", -166);
        cyc(5);             offs_is("R5 hold between strobes", -166);
        strobe(1'b0, 1'b1); offs_is("R2 climb step 2 with carry", -333);
        strobe(1'b0, 1'b1); offs_is("R2 climb reaches peak", -500);
        check("R9 duty with offset", int'(duty_out), 0);
    endtask

    task automatic t_fast_clear();
        ramp_ms = {16'd0, 16'd3};
        dith_en = 1'b0;
        cyc(2);
        offs_is("R4 instant descent", 0);
        check("R10 busy low after descent", int'(busy), 0);
    endtask

    task automatic t_partial_down();
        ramp_ms = {16'd5, 16'd3};
        dith_en = 1'b1;
        cyc(1);
        strobe(1'b0, 1'b1);
        strobe(1'b0, 1'b1); offs_is("R3 partial climb", -333);
        dith_en = 1'b0;
        cyc(1);
        strobe(1'b0, 1'b1); offs_is("R3 descent from partial 1", -233);
        strobe(1'b0, 1'b1); offs_is("R3 descent from partial 2", -133);
        strobe(1'b0, 1'b1); offs_is("R3 descent from partial 3", -33);
        check("R10 busy during descent", int'(busy), 1);
        strobe(1'b0, 1'b1); offs_is("R3 descent stops at zero", 0);
        check("R10 busy after descent", int'(busy), 0);
    endtask

    task automatic t_immediate_up();
        ramp_ms = {16'd5, 16'd0};
        dith_en = 1'b1;
        cyc(2);
        offs_is("R4 instant climb", -500);
    endtask

    task automatic t_triangle();
        wave_shape = 1'b0; period_us = 16'd4;
        cyc(2);             offs_is("R6 tri phase0", -500);
        strobe(1'b1, 1'b0); offs_is("R6 tri phase1", 0);
        strobe(1'b1, 1'b0); offs_is("R6 tri phase2", 500);
        strobe(1'b1, 1'b0); offs_is("R6 tri phase3", 0);
        strobe(1'b1, 1'b0); offs_is("R8 phase wraps", -500);
        period_us = 16'd5;
        cyc(2);             offs_is("R6 odd tri phase0", -500);
        strobe(1'b1, 1'b0); offs_is("R6 odd tri phase1", 0);
        strobe(1'b1, 1'b0); offs_is("R6 odd tri phase2", 500);
        strobe(1'b1, 1'b0); offs_is("R6 odd tri phase3", 500);
        strobe(1'b1, 1'b0); offs_is("R6 odd tri phase4", 0);
        strobe(1'b1, 1'b0); offs_is("R8 odd wrap", -500);
    endtask

    task automatic t_square();
        wave_shape = 1'b1; period_us = 16'd4;
        cyc(2);             offs_is("R7 sqr phase0", -500);
        strobe(1'b1, 1'b0); offs_is("R7 sqr phase1", -500);
        strobe(1'b1, 1'b0); offs_is("R7 sqr phase2", 500);
        strobe(1'b1, 1'b0); offs_is("R7 sqr phase3", 500);
        strobe(1'b1, 1'b0); offs_is("R7 sqr wrap", -500);
    endtask

    task automatic t_saturate();
        wave_shape = 1'b0; period_us = 16'd4; base_duty = 10'd800;
        cyc(2);
        check("R9 unclamped duty", int'(duty_out), 300);
        offs_is("R9 unclamped offset", -500);
        strobe(1'b1, 1'b0);
        strobe(1'b1, 1'b0);
        check("R9 clamp high duty", int'(duty_out), 1000);
        offs_is("R9 clamp high offset", 200);
        base_duty = 10'd200;
        strobe(1'b1, 1'b0);
        strobe(1'b1, 1'b0);
        check("R9 clamp low duty", int'(duty_out), 0);
        offs_is("R9 clamp low offset", -200);
    endtask

    task automatic t_amp_clamp();
        clear_all();
        amp_pct = 7'd120; wave_shape = 1'b0; period_us = 16'd8; base_duty = 10'd1000;
        dith_en = 1'b1;
        cyc(2);
        offs_is("R11 full height at phase0", -1000);
        strobe(1'b1, 1'b0);
        offs_is("R11 quarter point", -500);
        check("R11 duty at quarter point", int'(duty_out), 500);
        clear_all();
        amp_pct = 7'd50;
    endtask

    task automatic t_zero_amp();
        amp_pct = 7'd0; base_duty = 10'd500; period_us = 16'd4;
        dith_en = 1'b1;
        cyc(2);
        check("R10 busy with zero height", int'(busy), 1);
        for (int i = 0; i < 3; i++) begin
            strobe(1'b1, 1'b0);
            offs_is("R8 zero height offset", 0);
            check("R8 zero height duty", int'(duty_out), 500);
        end
        dith_en = 1'b0;
        cyc(2);
        check("R10 busy low when idle", int'(busy), 0);
        amp_pct = 7'd50;
    endtask

    task automatic t_same_cycle();
        ramp_ms = {16'd5, 16'd4}; wave_shape = 1'b0; period_us = 16'd2;
        dith_en = 1'b1;
        cyc(2);
        strobe(1'b1, 1'b1); offs_is("R2 R6 joint step 1", 125);
        strobe(1'b1, 1'b1); offs_is("R2 R6 joint step 2", -250);
        clear_all();
    endtask

    initial begin
        cyc(5);
        rst_n = 1'b1;
        t_reset();
        t_ramp_up();
        t_fast_clear();
        t_partial_down();
        t_immediate_up();
        t_triangle();
        t_square();
        t_saturate();
        t_amp_clamp();
        t_zero_amp();
        t_same_cycle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule